// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a purely combinational datapath stage that takes two operand words and produces one result word plus a carry flag. Its four-bit select input works in two layers. The low two select bits, together with a carry input, choose an arithmetic operation. The same two bits also choose a bitwise logic operation, and both stages compute their results in parallel. The high two select bits then pick the word that leaves the block: the arithmetic word, the logic word, the first operand shifted one place toward the LSB, or the first operand shifted one place toward the MSB.

The arithmetic stage is a single ripple adder. Its second input passes through a per-bit four-way selector that supplies zero, the second operand, the inverted second operand or all ones. Combined with the carry input, this gives eight operations: transfer, increment, add, add with carry, subtract with borrow, subtract, decrement and a second transfer. Each shift fills its vacated end bit from a dedicated serial input. The surrounding registers capture the result, so a whole register-to-register operation through the unit takes one clock cycle. The word width is a parameter with a default of 8 and must be at least 2.

Top module: `alsu_core`

## Requirements
- R1: With sel[3:2]=00 and sel[1:0]=00, result is op_a when carry_in=0 and op_a+1 modulo 2^W when carry_in=1; carry_out is the adder carry, so it is 1 only when op_a is all ones and carry_in=1.
- R2: With sel[3:2]=00 and sel[1:0]=01, {carry_out,result} equals op_a+op_b+carry_in computed in W+1 bits.
- R3: With sel[3:2]=00 and sel[1:0]=10, {carry_out,result} equals op_a+(~op_b)+carry_in in W+1 bits; with carry_in=1 this is op_a-op_b, and carry_out is 1 exactly when op_a >= op_b unsigned.
- R4: With sel[3:2]=00 and sel[1:0]=11, result is op_a-1 modulo 2^W when carry_in=0 (carry_out 1 unless op_a is zero) and result is op_a with carry_out=1 when carry_in=1.
- R5: With sel[3:2]=01, result is op_a AND op_b for sel[1:0]=00, OR for 01, XOR for 10, and bitwise NOT of op_a for 11; carry_in has no effect.
- R6: With sel[3:2]=10, result[W-2:0] equals op_a[W-1:1] and result[W-1] equals ser_right_in.
- R7: With sel[3:2]=11, result[W-1:1] equals op_a[W-2:0] and result[0] equals ser_left_in.
- R8: carry_out is 0 whenever sel[3:2] is not 00, whatever the operands and carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand; also the word that is shifted |
| op_b | input | W | Second operand for arithmetic and logic |
| carry_in | input | 1 | Carry into the adder LSB |
| sel | input | 4 | [3:2] output choice, [1:0] arithmetic and logic operation |
| ser_right_in | input | 1 | Bit that enters the MSB on a right shift |
| ser_left_in | input | 1 | Bit that enters the LSB on a left shift |
| result | output | W | Selected result word |
| carry_out | output | 1 | Adder carry when the arithmetic word is selected, else 0 |

## Verification
The embedded checks assume that every input is a defined 0 or 1 and that W is at least 2, so that both shift fields exist. They are evaluated whenever an input changes, so every combination the bench applies is examined. The stimulus keeps to these assumptions. It drives every input from a known value at a time away from the sampling edge, covers all sixteen select codes with both carry values, and targets the carry and wrap boundaries: all-ones plus one, zero minus one, and equal operands in subtraction.

// File: rtl/alsu_pkg.sv
// Package: shared select encodings for the arithmetic logic shift unit.
// Assumes: the two-bit fields are taken straight from the select port.
package alsu_pkg;

    // Output word choice, driven by sel[3:2].
    typedef enum logic [1:0] {
        OUT_ARITH = 2'b00,
        OUT_LOGIC = 2'b01,
        OUT_SHR   = 2'b10,
        OUT_SHL   = 2'b11
    } out_sel_e;

    // Logic operation, driven by sel[1:0].
    typedef enum logic [1:0] {
        LOP_AND  = 2'b00,
        LOP_OR   = 2'b01,
        LOP_XOR  = 2'b10,
        LOP_NOTA = 2'b11
    } logic_op_e;

    // Source of the adder second input, driven by sel[1:0].
    typedef enum logic [1:0] {
        Y_ZERO = 2'b00,
        Y_B    = 2'b01,
        Y_NB   = 2'b10,
        Y_ONES = 2'b11
    } y_src_e;

endpackage

// File: rtl/alsu_arith.sv
// Module: alsu_arith
// Ripple adder whose second input comes from a per-bit four-way selector
// (zero, B, NOT B, all ones). Gives eight operations from two select bits
// and the carry input. Assumes W >= 1; purely combinational.
module alsu_arith
    import alsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic [1:0]   op,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W-1:0] y_word;

    // One selector per bit picks the adder second input.
    for (genvar i = 0; i < W; i++) begin : g_ymux
        always_comb begin
            unique case (y_src_e'(op))
                Y_ZERO:  y_word[i] = 1'b0;
                Y_B:     y_word[i] = b[i];
                Y_NB:    y_word[i] = ~b[i];
                default: y_word[i] = 1'b1;
            endcase
        end
    end

    // Full-adder chain from LSB to MSB; the last carry leaves as cout.
    always_comb begin
        logic cy;
        cy = cin;
        for (int i = 0; i < W; i++) begin
            sum[i] = a[i] ^ y_word[i] ^ cy;
            cy     = (a[i] & y_word[i]) | (cy & (a[i] ^ y_word[i]));
        end
        cout = cy;
    end

    // Invariants of the arithmetic codes, checked on every change.
    always_comb begin
        if (op == 2'b00 && cin && (&a)) begin
            p_inc_wrap_r1: assert (sum == '0 && cout)
                else $error("increment of all ones must wrap with carry");
        end
        if (op == 2'b10 && cin) begin
            p_sub_borrow_r3: assert (cout == (a >= b))
                else $error("subtract carry must mean no borrow");
        end
        if (op == 2'b11 && cin) begin
            p_hold_identity_r4: assert (sum == a && cout)
                else $error("A plus ones plus one must return A with carry");
        end
    end

endmodule

// File: rtl/alsu_logic.sv
// Module: alsu_logic
// Bitwise logic stage: AND, OR, XOR or NOT of the first operand, chosen by
// two select bits shared by every bit position. Purely combinational.
module alsu_logic
    import alsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   op,
    output logic [W-1:0] res
);

    // Every bit uses the same operation select.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (logic_op_e'(op))
                LOP_AND:  res[i] = a[i] & b[i];
                LOP_OR:   res[i] = a[i] | b[i];
                LOP_XOR:  res[i] = a[i] ^ b[i];
                default:  res[i] = ~a[i];
            endcase
        end
    end

    // The complement code must ignore the second operand.
    always_comb begin
        if (op == 2'b11) begin
            p_not_a_r5: assert (res == ~a)
                else $error("complement code must invert A only");
        end
    end

endmodule

// File: rtl/alsu_shift.sv
// Module: alsu_shift
// Single-place shifter of the first operand in both directions; each
// vacated end bit takes its own serial input. Assumes W >= 2.
module alsu_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         fill_msb,
    input  logic         fill_lsb,
    output logic [W-1:0] shr,
    output logic [W-1:0] shl
);

    localparam int TOP = W - 1;

    // Each output bit takes its neighbour, end bits take serial inputs.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == TOP) begin : g_top
            assign shr[i] = fill_msb;
        end else begin : g_mid_r
            assign shr[i] = a[i+1];
        end
        if (i == 0) begin : g_bot
            assign shl[i] = fill_lsb;
        end else begin : g_mid_l
            assign shl[i] = a[i-1];
        end
    end

endmodule

// File: rtl/alsu_core.sv
// Module: alsu_core (top)
// Arithmetic logic shift unit: arithmetic and logic stages run in parallel
// on sel[1:0]; sel[3:2] picks arithmetic, logic, right shift or left shift.
// Carry leaves only with the arithmetic word. Assumes W >= 2.
module alsu_core
    import alsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    input  logic [3:0]   sel,
    input  logic         ser_right_in,
    input  logic         ser_left_in,
    output logic [W-1:0] result,
    output logic         carry_out
);

    localparam int MSB = W - 1;

    logic [W-1:0] arith_w;
    logic         arith_c;
    logic [W-1:0] logic_w;
    logic [W-1:0] shr_w;
    logic [W-1:0] shl_w;

    alsu_arith #(.W(W)) arith_i (
        .a    (op_a),
        .b    (op_b),
        .cin  (carry_in),
        .op   (sel[1:0]),
        .sum  (arith_w),
        .cout (arith_c)
    );

    alsu_logic #(.W(W)) logic_i (
        .a   (op_a),
        .b   (op_b),
        .op  (sel[1:0]),
        .res (logic_w)
    );

    alsu_shift #(.W(W)) shift_i (
        .a        (op_a),
        .fill_msb (ser_right_in),
        .fill_lsb (ser_left_in),
        .shr      (shr_w),
        .shl      (shl_w)
    );

    // Output selector: one of four stage words, carry only with arithmetic.
    always_comb begin
        carry_out = 1'b0;
        unique case (out_sel_e'(sel[3:2]))
            OUT_ARITH: begin
                result    = arith_w;
                carry_out = arith_c;
            end
            OUT_LOGIC: result = logic_w;
            OUT_SHR:   result = shr_w;
            default:   result = shl_w;
        endcase
    end

    // Port-level checks on carry gating and shift fill.
    always_comb begin
        if (sel[3:2] != 2'b00) begin
            p_carry_quiet_r8: assert (!carry_out)
                else $error("carry must be low outside arithmetic");
        end
        if (sel[3:2] == 2'b10) begin
            p_shr_fill_r6: assert (result[MSB] == ser_right_in && result[MSB-1:0] == op_a[MSB:1])
                else $error("right shift field mismatch");
        end
        if (sel[3:2] == 2'b11) begin
            p_shl_fill_r7: assert (result[0] == ser_left_in && result[MSB:1] == op_a[MSB-1:0])
                else $error("left shift field mismatch");
        end
    end

endmodule

// File: tb/alsu_core_tb_top.sv
// Scoreboard bench: the driver applies inputs after a rising edge and queues
// the expected word; the monitor compares at the following falling edge.
module alsu_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    typedef struct {
        logic [W-1:0] res;
        logic         cout;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [3:0]   sel = '0;
    logic         ser_right_in = 1'b0;
    logic         ser_left_in = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    alsu_core #(.W(W)) dut_i (
        .op_a         (op_a),
        .op_b         (op_b),
        .carry_in     (carry_in),
        .sel          (sel),
        .ser_right_in (ser_right_in),
        .ser_left_in  (ser_left_in),
        .result       (result),
        .carry_out    (carry_out)
    );

    // Requirement tag for a select code.
    function automatic string req_of(input logic [3:0] s);
        case (s[3:2])
            2'b00: case (s[1:0])
                2'b00: return "R1";
                2'b01: return "R2";
                2'b10: return "R3";
                default: return "R4";
            endcase
            2'b01: return "R5";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Reference model written from the requirement list.
    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic ci, input logic [3:0] s,
                                   input logic sr, input logic sl);
        exp_t   e;
        logic [W:0]   wide;
        logic [W-1:0] y;
        e.cout = 1'b0;
        case (s[1:0])
            2'b00: y = '0;
            2'b01: y = b;
            2'b10: y = ~b;
            default: y = '1;
        endcase
        wide = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, ci};
        case (s[3:2])
            2'b00: begin e.res = wide[W-1:0]; e.cout = wide[W]; end
            2'b01: case (s[1:0])
                2'b00: e.res = a & b;
                2'b01: e.res = a | b;
                2'b10: e.res = a ^ b;
                default: e.res = ~a;
            endcase
            2'b10: e.res = {sr, a[W-1:1]};
            default: e.res = {a[W-2:0], sl};
        endcase
        e.req = req_of(s);
        return e;
    endfunction

    // Driver: apply one input set and queue its expectation.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci, input logic [3:0] s,
                         input logic sr, input logic sl);
        @(posedge clk);
        #1;
        op_a = a; op_b = b; carry_in = ci; sel = s;
        ser_right_in = sr; ser_left_in = sl;
        sb_q.push_back(model(a, b, ci, s, sr, sl));
    endtask

    // Driver with a fixed expectation written out by hand.
    task automatic drive_fixed(input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic ci, input logic [3:0] s,
                               input logic sr, input logic sl,
                               input logic [W-1:0] xr, input logic xc, input string rq);
        exp_t e;
        @(posedge clk);
        #1;
        op_a = a; op_b = b; carry_in = ci; sel = s;
        ser_right_in = sr; ser_left_in = sl;
        e.res = xr; e.cout = xc; e.req = rq;
        sb_q.push_back(e);
    endtask

    // Monitor: compare one queued expectation per falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (result !== e.res || carry_out !== e.cout) begin
                n_fail++;
                $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                         e.req, result, carry_out, e.res, e.cout);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: result=%h carry=%b expected completion", result, carry_out);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        // Idle state: all-zero inputs give a zero word and no carry (R1).
        drive_fixed(8'h00, 8'h00, 1'b0, 4'b0000, 1'b0, 1'b0, 8'h00, 1'b0, "R1");
        // R1 transfer and increment, including wrap.
        drive_fixed(8'h7F, 8'h00, 1'b0, 4'b0000, 1'b0, 1'b0, 8'h7F, 1'b0, "R1");
        drive_fixed(8'h7F, 8'h00, 1'b1, 4'b0000, 1'b0, 1'b0, 8'h80, 1'b0, "R1");
        drive_fixed(8'hFF, 8'h00, 1'b1, 4'b0000, 1'b0, 1'b0, 8'h00, 1'b1, "R1");
        // R2 add and add with carry.
        drive_fixed(8'h12, 8'h34, 1'b0, 4'b0001, 1'b0, 1'b0, 8'h46, 1'b0, "R2");
        drive_fixed(8'hFF, 8'h01, 1'b0, 4'b0001, 1'b0, 1'b0, 8'h00, 1'b1, "R2");
        drive_fixed(8'h10, 8'h20, 1'b1, 4'b0001, 1'b0, 1'b0, 8'h31, 1'b0, "R2");
        // R3 subtract, borrow and equal operands.
        drive_fixed(8'h50, 8'h30, 1'b1, 4'b0010, 1'b0, 1'b0, 8'h20, 1'b1, "R3");
        drive_fixed(8'h30, 8'h50, 1'b1, 4'b0010, 1'b0, 1'b0, 8'hE0, 1'b0, "R3");
        drive_fixed(8'h50, 8'h30, 1'b0, 4'b0010, 1'b0, 1'b0, 8'h1F, 1'b1, "R3");
        drive_fixed(8'h44, 8'h44, 1'b1, 4'b0010, 1'b0, 1'b0, 8'h00, 1'b1, "R3");
        // R4 decrement and second transfer.
        drive_fixed(8'h00, 8'h00, 1'b0, 4'b0011, 1'b0, 1'b0, 8'hFF, 1'b0, "R4");
        drive_fixed(8'h05, 8'h00, 1'b0, 4'b0011, 1'b0, 1'b0, 8'h04, 1'b1, "R4");
        drive_fixed(8'hA5, 8'h3C, 1'b1, 4'b0011, 1'b0, 1'b0, 8'hA5, 1'b1, "R4");
        // R5 logic operations, carry_in set to show it has no effect.
        drive_fixed(8'hF0, 8'h3C, 1'b1, 4'b0100, 1'b0, 1'b0, 8'h30, 1'b0, "R5");
        drive_fixed(8'hF0, 8'h3C, 1'b1, 4'b0101, 1'b0, 1'b0, 8'hFC, 1'b0, "R5");
        drive_fixed(8'hF0, 8'h3C, 1'b0, 4'b0110, 1'b0, 1'b0, 8'hCC, 1'b0, "R5");
        drive_fixed(8'hF0, 8'h3C, 1'b1, 4'b0111, 1'b0, 1'b0, 8'h0F, 1'b0, "R5");
        // R6 right shift with both fill values.
        drive_fixed(8'h81, 8'h00, 1'b0, 4'b1000, 1'b0, 1'b1, 8'h40, 1'b0, "R6");
        drive_fixed(8'h81, 8'h00, 1'b0, 4'b1000, 1'b1, 1'b0, 8'hC0, 1'b0, "R6");
        // R7 left shift with both fill values.
        drive_fixed(8'h81, 8'h00, 1'b0, 4'b1100, 1'b1, 1'b0, 8'h02, 1'b0, "R7");
        drive_fixed(8'h81, 8'h00, 1'b0, 4'b1100, 1'b0, 1'b1, 8'h03, 1'b0, "R7");
        // R8 carry gated off when a carry-producing sum is not selected.
        drive_fixed(8'hFF, 8'hFF, 1'b1, 4'b0101, 1'b0, 1'b0, 8'hFF, 1'b0, "R8");
        drive_fixed(8'hFF, 8'h01, 1'b1, 4'b1001, 1'b1, 1'b1, 8'hFF, 1'b0, "R8");
        drive_fixed(8'hFF, 8'h01, 1'b1, 4'b1101, 1'b1, 1'b1, 8'hFF, 1'b0, "R8");
        // Sweep of every select code and carry with varied operands.
        for (int k = 0; k < 640; k++) begin
            logic [3:0] s;
            s = 4'(k % 16);
            drive(W'($urandom), W'($urandom), 1'((k / 16) % 2), s,
                  1'($urandom), 1'($urandom));
        end
        // Corner operands across all select codes.
        for (int k = 0; k < 32; k++) begin
            drive(8'hFF, 8'h00, 1'(k / 16), 4'(k % 16), 1'b1, 1'b1);
            drive(8'h00, 8'hFF, 1'(k / 16), 4'(k % 16), 1'b0, 1'b0);
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule